// File: doc/BRIEF.md
# Indirect colour grading table port

This block lets a byte-wide host bus reach six internal curve tables through a window of four registers. A select register names the table and the access mode. An index register names one of 64 slots. A pair of value registers moves the 16-bit content of that slot one byte at a time.

A write of the high value byte is parked in a holding register. The full slot is written at once when the low byte follows. A read of the low value byte captures the whole slot, so the high byte read that follows comes from the same moment. In bulk mode each access to the low value byte moves the index on by one, so a host can stream a whole table in one pass. Each table keeps only its own width: the hue-to-hue curve keeps 14 signed bits and the other five keep 12 unsigned bits. Table codes 6 and 7 are reserved.

Window addresses are 0 for select, 1 for index, 2 for the low value byte and 3 for the high value byte. An access is one cycle with `host_cs` high. Read data is registered: it appears after the clock edge that samples the read strobe and stays until the next read.

Top module: `grade_table_port`

## Requirements
- R1: After reset, select and index read back as 0x00, and `host_rdata` is 0x00 before any read.
- R2: Writing address 0 stores bits 7:5 as the table code and bit 0 as the mode (1 = bulk, 0 = normal). Bits 4:1 (page) always read back as zero, so a read of address 0 returns {code, 4'b0000, mode}.
- R3: Writing address 1 keeps only bits 5:0 as the index. A read of address 1 returns {2'b00, index}.
- R4: A write of address 3 changes only the holding byte and leaves the slot unchanged. A write of address 2 stores {holding byte, written byte} into slot [index] of the selected table.
- R5: A read of address 2 returns bits 7:0 of the slot and captures all 16 bits. A following read of address 3 returns bits 15:8 of that capture, even if the slot was rewritten in between.
- R6: In bulk mode, a read or a write of address 2 acts on the current index, and the index then becomes index+1, wrapping from 63 to 0.
- R7: In normal mode, accesses to addresses 2 and 3 never change the index. In bulk mode, accesses to address 3 never change the index.
- R8: Table code 0 stores 14 bits and reads back sign-extended from bit 13. Codes 1 to 5 store 12 bits and read back bits 15:12 as zero.
- R9: With code 6 or 7 selected, a write of address 2 stores nothing, a read of address 2 returns zero and captures zero, and the index does not advance in either mode.
- R10: `host_rdata` changes only on the edge that samples a read strobe. Writes and idle cycles leave it unchanged.
- R11: A write to a slot of one table leaves the same slot of every other table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs | input | 1 | One-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Window register: 0 select, 1 index, 2 value low, 3 value high |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |

## Verification
In bulk mode, two actions fall on one clock edge: the commit or capture of the low value byte and the index increment. The bench streams all six tables with back-to-back bulk writes and then reads them back in bulk. A slot that was committed to, or captured from, the already-advanced index would show up as a mismatch against the bench model. The wrap from 63 to 0 is driven on purpose. A rewrite of a slot between a low byte read and the matching high byte read checks that the capture taken at the low read is the value returned.

// File: rtl/ctab_pkg.sv
// Package: shared sizes and the per-table storage width rule for the
// colour grading table port. Assumes every slot is read out at SLOT_W bits.
package ctab_pkg;
    localparam int SLOT_W  = 16;
    localparam int IDX_W   = 6;
    localparam int NUM_TBL = 6;
    localparam int DEPTH   = 1 << IDX_W;

    // Window register addresses seen by the host
    localparam logic [1:0] A_SEL = 2'd0;
    localparam logic [1:0] A_IDX = 2'd1;
    localparam logic [1:0] A_LO  = 2'd2;
    localparam logic [1:0] A_HI  = 2'd3;

    // Table 0 is the signed hue curve; the rest are 12-bit unsigned
    function automatic int tbl_width(input int t);
        return (t == 0) ? 14 : 12;
    endfunction

    function automatic bit tbl_signed(input int t);
        return (t == 0);
    endfunction
endpackage

// File: rtl/ctab_bank.sv
// Module: one curve table. Stores W bits per slot and widens the read
// value to SLOT_W, sign-extending or zero-filling by parameter.
// Assumes W < SLOT_W. The storage is not reset.
module ctab_bank
    import ctab_pkg::*;
#(
    parameter int W   = 12,
    parameter bit SGN = 1'b0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [SLOT_W-1:0] wdata,
    output logic [SLOT_W-1:0] rdata
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] raw;
    logic [SLOT_W-1:W] unused_top;

    assign unused_top = wdata[SLOT_W-1:W];

    // Store the truncated slot value on a commit
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata[W-1:0];
    end

    assign raw = mem[addr];

    generate
        if (SGN) begin : g_sext
            assign rdata = {{(SLOT_W-W){raw[W-1]}}, raw};
        end else begin : g_zext
            assign rdata = {{(SLOT_W-W){1'b0}}, raw};
        end
    endgenerate
endmodule

// File: rtl/ctab_regs.sv
// Module: host window registers. Holds the select, index and the two
// holding bytes, decodes accesses, drives the table commit and registers
// the read byte. Assumes one access per cycle, with single-cycle strobes.
module ctab_regs
    import ctab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [7:0]        sel_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              tbl_wr,
    output logic [SLOT_W-1:0] tbl_wdata,
    input  logic [SLOT_W-1:0] tbl_rdata
);
    logic [7:0]        hold_hi;
    logic [SLOT_W-1:0] hold_rd;
    logic              tbl_ok;
    logic              lo_acc;
    logic              rd_acc;
    logic              wr_acc;
    logic [5:0]        unused_bits;

    assign unused_bits = {host_wdata[4:1], host_wdata[7:6]};
    assign tbl_ok    = int'(sel_q[7:5]) < NUM_TBL;
    assign rd_acc    = host_cs && !host_we;
    assign wr_acc    = host_cs && host_we;
    assign lo_acc    = host_cs && (host_addr == A_LO) && tbl_ok;
    assign tbl_wr    = lo_acc && host_we;
    assign tbl_wdata = {hold_hi, host_wdata};

    // Select, index and high holding byte; the index advances on bulk low access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            idx_q   <= '0;
            hold_hi <= '0;
        end else begin
            if (wr_acc && host_addr == A_SEL)
                sel_q <= {host_wdata[7:5], 4'b0000, host_wdata[0]};
            if (wr_acc && host_addr == A_HI)
                hold_hi <= host_wdata;
            if (wr_acc && host_addr == A_IDX)
                idx_q <= host_wdata[IDX_W-1:0];
            else if (lo_acc && sel_q[0])
                idx_q <= idx_q + 1'b1;
        end
    end

    // Registered read byte and the slot capture taken at a low byte read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            hold_rd    <= '0;
        end else if (rd_acc) begin
            unique case (host_addr)
                A_SEL: host_rdata <= sel_q;
                A_IDX: host_rdata <= {{(8-IDX_W){1'b0}}, idx_q};
                A_LO: begin
                    host_rdata <= tbl_ok ? tbl_rdata[7:0] : 8'h00;
                    hold_rd    <= tbl_ok ? tbl_rdata : '0;
                end
                default: host_rdata <= hold_rd[15:8];
            endcase
        end
    end
endmodule

// File: rtl/grade_table_port.sv
// Module: top of the colour grading table port. Connects the host window
// to NUM_TBL curve tables and steers commits and reads by the table code.
// Assumes codes at or above NUM_TBL are reserved and map to no table.
module grade_table_port
    import ctab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_cs,
    input  logic       host_we,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    logic [7:0]        sel_q;
    logic [IDX_W-1:0]  idx_q;
    logic              tbl_wr;
    logic [SLOT_W-1:0] tbl_wdata;
    logic [SLOT_W-1:0] rd_slot;
    logic [SLOT_W-1:0] bank_rd [NUM_TBL];

    ctab_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .sel_q      (sel_q),
        .idx_q      (idx_q),
        .tbl_wr     (tbl_wr),
        .tbl_wdata  (tbl_wdata),
        .tbl_rdata  (rd_slot)
    );

    generate
        for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
            ctab_bank #(
                .W   (tbl_width(t)),
                .SGN (tbl_signed(t))
            ) u_bank (
                .clk   (clk),
                .we    (tbl_wr && (int'(sel_q[7:5]) == t)),
                .addr  (idx_q),
                .wdata (tbl_wdata),
                .rdata (bank_rd[t])
            );
        end
    endgenerate

    // Pick the read value of the selected table; reserved codes give zero
    always_comb begin
        rd_slot = '0;
        for (int t = 0; t < NUM_TBL; t++)
            if (int'(sel_q[7:5]) == t) rd_slot = bank_rd[t];
    end
endmodule

// File: rtl/grade_table_port_chk.sv
// Module: property checker for the colour grading table port, bound to the
// top. Watches the host pins with the select and index state.
module grade_table_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_cs,
    input logic       host_we,
    input logic [1:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic [7:0] sel_q,
    input logic [5:0] idx_q
);
    // R6
    bulk_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_addr == 2'd2 && sel_q[0] && sel_q[7:5] < 3'd6)
        |=> idx_q == $past(idx_q) + 6'd1);

    // R7
    normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_addr[1] && !(sel_q[0] && host_addr == 2'd2))
        |=> $stable(idx_q));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && !host_we && host_addr == 2'd2 && sel_q[7:5] >= 3'd6)
        |=> host_rdata == 8'h00);

    // R9
    reserved_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_addr == 2'd2 && sel_q[7:5] >= 3'd6)
        |=> $stable(idx_q));

    // R3
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_we && host_addr == 2'd1)
        |=> idx_q == $past(host_wdata[5:0]));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cs && !host_we) |=> $stable(host_rdata));

    // R2
    page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && !host_we && host_addr == 2'd0)
        |=> host_rdata[4:1] == 4'b0000);
endmodule

bind grade_table_port grade_table_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .sel_q      (sel_q),
    .idx_q      (idx_q)
);

// File: tb/tb_grade_table_port.sv
// Bench: a model-driven check of the grading table window, using directed
// corners and seeded random accesses.
module tb_grade_table_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the window state
    logic [15:0] mdl [0:5][0:63];
    logic [7:0]  m_sel = 8'h00;
    logic [5:0]  m_idx = 6'd0;
    logic [7:0]  m_hh = 8'h00;
    logic [15:0] m_hr = 16'h0000;
    logic [7:0]  m_last = 8'h00;

    grade_table_port dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] canon(input int t, input logic [15:0] v);
        return (t == 0) ? {{2{v[13]}}, v[13:0]} : {4'h0, v[11:0]};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle driven at a falling edge, result sampled a cycle later
    task automatic bus(input bit we, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] q);
        @(negedge clk);
        host_cs = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
        q = host_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] q;
        int t;
        bit ok;
        t = int'(m_sel[7:5]);
        ok = t < 6;
        case (a)
            2'd0: m_sel = {d[7:5], 4'b0000, d[0]};
            2'd1: m_idx = d[5:0];
            2'd2: begin
                if (ok) mdl[t][m_idx] = canon(t, {m_hh, d});
                if (ok && m_sel[0]) m_idx = m_idx + 6'd1;
            end
            default: m_hh = d;
        endcase
        bus(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        logic [7:0] q;
        logic [7:0] e;
        logic [15:0] v;
        int t;
        bit ok;
        t = int'(m_sel[7:5]);
        ok = t < 6;
        case (a)
            2'd0: e = m_sel;
            2'd1: e = {2'b00, m_idx};
            2'd2: begin
                v = ok ? mdl[t][m_idx] : 16'h0000;
                m_hr = v;
                e = v[7:0];
                if (ok && m_sel[0]) m_idx = m_idx + 6'd1;
            end
            default: e = m_hr[15:8];
        endcase
        m_last = e;
        bus(1'b0, a, 8'h00, q);
        check(tag, q, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", host_rdata, 8'h00);
        rd(2'd0, "R1 select");
        rd(2'd1, "R1 index");

        // R2 select with page bits forced to zero
        wr(2'd0, 8'hFF);
        rd(2'd0, "R2");
        wr(2'd0, 8'h5E);
        rd(2'd0, "R2");
        // R3 index upper bits dropped
        wr(2'd1, 8'hC5);
        rd(2'd1, "R3");

        // R6 bulk fill of every table, wrapping back to index 0
        for (int t = 0; t < 6; t++) begin
            wr(2'd0, {t[2:0], 4'b0000, 1'b1});
            wr(2'd1, 8'h00);
            for (int i = 0; i < 64; i++) begin
                wr(2'd3, 8'($urandom));
                wr(2'd2, 8'($urandom));
            end
            rd(2'd1, "R6 wrap after fill");
        end
        // R8 R5 bulk read-back with width rules
        for (int t = 0; t < 6; t++) begin
            wr(2'd0, {t[2:0], 4'b0000, 1'b1});
            wr(2'd1, 8'h00);
            for (int i = 0; i < 64; i++) begin
                rd(2'd2, "R8 low");
                rd(2'd3, "R8 high");
            end
        end
        // R8 sign extension on table 0
        wr(2'd0, 8'h00); wr(2'd1, 8'd4);
        wr(2'd3, 8'h2A); wr(2'd2, 8'h11);
        rd(2'd2, "R8 signed low"); rd(2'd3, "R8 signed high");
        wr(2'd3, 8'hD5); wr(2'd2, 8'h77);
        rd(2'd2, "R8 positive low"); rd(2'd3, "R8 positive high");
        // R8 12-bit table drops the top nibble
        wr(2'd0, 8'h60);
        wr(2'd3, 8'hFF); wr(2'd2, 8'hEE);
        rd(2'd2, "R8 12bit low"); rd(2'd3, "R8 12bit high");

        // R9 reserved code in bulk mode
        wr(2'd0, 8'hC1); wr(2'd1, 8'd3);
        wr(2'd3, 8'hAB); wr(2'd2, 8'hCD);
        rd(2'd1, "R9 no advance on write");
        rd(2'd2, "R9 low zero");
        rd(2'd3, "R9 high zero");
        rd(2'd1, "R9 no advance on read");
        wr(2'd0, 8'hE0);
        rd(2'd2, "R9 code 7 zero");
        // R11 other tables untouched by the reserved write
        for (int t = 0; t < 6; t++) begin
            wr(2'd0, {t[2:0], 5'b00000});
            rd(2'd2, "R11 slot 3");
        end

        // R5 capture survives a rewrite
        wr(2'd0, 8'h40); wr(2'd1, 8'd7);
        rd(2'd2, "R5 low");
        wr(2'd3, 8'h0A); wr(2'd2, 8'hB3);
        rd(2'd3, "R5 held high");
        rd(2'd2, "R4 commit low");
        rd(2'd3, "R4 commit high");
        // R4 high write alone leaves the slot
        wr(2'd3, 8'h05);
        rd(2'd2, "R4 high only low");
        rd(2'd3, "R4 high only high");
        // R7 normal mode keeps index
        rd(2'd1, "R7 index");
        // R10 writes and idle cycles keep rdata
        wr(2'd1, 8'd9);
        repeat (3) @(negedge clk);
        check("R10", host_rdata, m_last);
        // R11 table 0 slot 9 write, table 1 slot 9 unchanged
        wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd2, 8'h23);
        wr(2'd0, 8'h20);
        rd(2'd2, "R11 neighbour low"); rd(2'd3, "R11 neighbour high");
        // R6 explicit wrap from 62
        wr(2'd0, 8'h21); wr(2'd1, 8'd62);
        rd(2'd2, "R6 slot 62"); rd(2'd2, "R6 slot 63");
        rd(2'd1, "R6 wrapped index");
        // R7 high access in bulk mode keeps index
        rd(2'd3, "R7 bulk high");
        wr(2'd3, 8'h33);
        rd(2'd1, "R7 bulk index");

        // Random mix of all accesses
        for (int n = 0; n < 1500; n++) begin
            logic [1:0] a;
            a = 2'($urandom);
            if ($urandom % 2 == 0) begin
                if (a == 2'd0 && ($urandom % 3) != 0) a = 2'd2;
                wr(a, 8'($urandom));
            end else begin
                rd(a, "R10 random read");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule